// File: doc/BRIEF.md
# Dithered Pulse-Density Rate Multiplier

This block turns a parallel level of `WIDTH` bits into a serial stream of single-bit pulses. The fraction of ones in the stream is `level / 2^WIDTH`. A free-running sample counter advances once for each enabled sample. Its bits, taken in reverse order, form a dither word. The carry out of `level + dither` becomes the next registered output bit. The sum bits themselves are never formed.

Because the reversed counter's top bit is the counter's lowest bit, the dither word changes on every sample. The ones are therefore spread through the window rather than bunched at its start. A typical use is as the feedback path of an oversampled integrator or as a cheap pulse-density DAC. In both cases `sample_en` is tied to the system's sample strobe. The carry logic can be built as a ripple chain of carry cells or as a magnitude compare, and both builds give identical streams.

Top module: `dither_rate_mult`

## Requirements
- R1: While `rst` is high at a rising edge, `bit_out` is 0 after that edge and the sample count returns to 0, so the first enabled sample after reset uses a dither word of 0.
- R2: At the k-th enabled sample since reset (k counted from 0, modulo 2^WIDTH), `bit_out` after that edge equals 1 exactly when `level + bitrev(k mod 2^WIDTH) >= 2^WIDTH`. Here bitrev maps counter bit i to dither bit WIDTH-1-i.
- R3: At a rising edge with `sample_en` low, `bit_out` holds its value and the sample count does not advance, whatever `level` is.
- R4: With `level` = 0, every enabled sample gives `bit_out` = 0.
- R5: With `level` = 2^WIDTH-1, every enabled sample gives 1, except samples whose count is a multiple of 2^WIDTH, which give 0.
- R6: Over any 2^WIDTH consecutive enabled samples with a constant `level` V, exactly V of the output bits are 1.
- R7: The dither MSB toggles on every enabled sample. With `level` = 2^(WIDTH-1), the output alternates 0,1,0,1,… starting with 0 after reset.
- R8: The ripple-carry build (`CARRY_STYLE` = CARRY_RIPPLE) and the compare build (CARRY_COMPARE) give identical `bit_out` sequences for identical inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Sample strobe; when high, the counter advances and the output updates |
| level | input | WIDTH | Unsigned level whose density is produced |
| bit_out | output | 1 | Registered pulse-density output |

## Verification
A corrupted sample counter or a miswired bit reversal shows at `bit_out` within one or two enabled samples. The clearest case is mid-scale, where the output must alternate on every sample. A wrong carry in the top bits shows as a wrong one count over a 2^WIDTH window near full scale. A counter or output register that moves without `sample_en` shows as a difference from the reference on the very next clock. Because the reference model recomputes the expected bit on every clock and both carry builds are compared against it, any divergence is reported in the cycle where it first appears.

// File: rtl/ratemult_pkg.sv
package ratemult_pkg;

   typedef enum logic [0:0] {
      CARRY_RIPPLE  = 1'b0,
      CARRY_COMPARE = 1'b1
   } carry_style_e;

   localparam int unsigned RM_MIN_WIDTH = 2;
   localparam int unsigned RM_MAX_WIDTH = 30;

endpackage

// File: rtl/rm_sample_counter.sv
module rm_sample_counter #(
   parameter int unsigned WIDTH = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   output logic [WIDTH-1:0] cnt
);

   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (adv) begin
         cnt <= cnt + ONE;
      end
   end

endmodule

// File: rtl/rm_bit_reverse.sv
module rm_bit_reverse #(
   parameter int unsigned WIDTH = 9
) (
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   localparam int unsigned TOP = WIDTH - 1;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_swap
         assign dout[TOP-i] = din[i];
      end
   endgenerate

endmodule

// File: rtl/rm_carry_unit.sv
module rm_carry_unit
   import ratemult_pkg::*;
#(
   parameter int unsigned  WIDTH = 9,
   parameter carry_style_e STYLE = CARRY_RIPPLE
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic             carry
);

   generate
      if (STYLE == CARRY_RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            assign chain[i+1] = (a[i] & b[i]) | ((a[i] | b[i]) & chain[i]);
         end
         assign carry = chain[WIDTH];
      end else begin : g_compare
         // a + b overflows exactly when a exceeds the complement of b
         assign carry = (a > ~b);
      end
   endgenerate

endmodule

// File: rtl/dither_rate_mult.sv
module dither_rate_mult
   import ratemult_pkg::*;
#(
   parameter int unsigned  WIDTH       = 9,
   parameter carry_style_e CARRY_STYLE = CARRY_RIPPLE
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sample_en,
   input  logic [WIDTH-1:0] level,
   output logic             bit_out
);

   generate
      if (WIDTH < RM_MIN_WIDTH || WIDTH > RM_MAX_WIDTH) begin : g_bad_width
         $error("dither_rate_mult: WIDTH out of supported range");
      end
   endgenerate

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] dither;
   logic             carry_nxt;

   rm_sample_counter #(.WIDTH(WIDTH)) u_cnt (
      .clk (clk),
      .rst (rst),
      .adv (sample_en),
      .cnt (cnt_q)
   );

   rm_bit_reverse #(.WIDTH(WIDTH)) u_rev (
      .din  (cnt_q),
      .dout (dither)
   );

   rm_carry_unit #(.WIDTH(WIDTH), .STYLE(CARRY_STYLE)) u_carry (
      .a     (level),
      .b     (dither),
      .carry (carry_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         bit_out <= 1'b0;
      end else if (sample_en) begin
         bit_out <= carry_nxt;
      end
   end

endmodule

// File: rtl/rm_checker.sv
module rm_checker #(
   parameter int unsigned WIDTH = 9
) (
   input logic             clk,
   input logic             rst,
   input logic             en,
   input logic [WIDTH-1:0] value,
   input logic             bit_out,
   input logic [WIDTH-1:0] cnt
);

   localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] HALF = {1'b1, {(WIDTH-1){1'b0}}};

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> !bit_out);  // R1
   AST_RESET_COUNT: assert property (@(posedge clk) rst |=> (cnt == '0));  // R1
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(bit_out));  // R3
   AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(cnt));  // R3
   AST_ZERO_LEVEL: assert property (@(posedge clk) disable iff (rst) (en && value == '0) |=> !bit_out);  // R4
   AST_FULL_LEVEL: assert property (@(posedge clk) disable iff (rst) (en && value == FULL && cnt != '0) |=> bit_out);  // R5
   AST_FULL_GAP: assert property (@(posedge clk) disable iff (rst) (en && value == FULL && cnt == '0) |=> !bit_out);  // R5
   AST_HALF_TOGGLE: assert property (@(posedge clk) disable iff (rst) (en && value == HALF) |=> (bit_out == $past(cnt[0])));  // R7

endmodule

bind dither_rate_mult rm_checker #(.WIDTH(WIDTH)) u_rm_checker (
   .clk     (clk),
   .rst     (rst),
   .en      (sample_en),
   .value   (level),
   .bit_out (bit_out),
   .cnt     (cnt_q)
);

// File: tb/test_dither_rate_mult.sv
module test_dither_rate_mult;
   import ratemult_pkg::*;

   localparam int unsigned N    = 9;
   localparam int unsigned SPAN = 1 << N;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         sample_en = 1'b0;
   logic [N-1:0] level = '0;
   logic         out_rip;
   logic         out_cmp;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   int  k_model   = 0;
   bit  exp_bit   = 1'b0;

   always #10 clk = ~clk;

   dither_rate_mult #(.WIDTH(N), .CARRY_STYLE(CARRY_RIPPLE)) i_dither_rate_mult (
      .clk(clk), .rst(rst), .sample_en(sample_en), .level(level), .bit_out(out_rip));

   dither_rate_mult #(.WIDTH(N), .CARRY_STYLE(CARRY_COMPARE)) i_dither_rate_mult_alt (
      .clk(clk), .rst(rst), .sample_en(sample_en), .level(level), .bit_out(out_cmp));

   function automatic int rev_of(input int k);
      int r = 0;
      for (int i = 0; i < N; i++) begin
         if (((k >> i) & 1) == 1) r = r + (1 << (N - 1 - i));
      end
      return r;
   endfunction

   task automatic check(input string tag, input bit act, input bit exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0b expected %0b (sample %0d)", tag, act, exp, k_model);
      end
   endtask

   // Drive one clock: inputs set at the falling edge, results sampled at the next falling edge.
   task automatic step(input bit r, input bit en, input int v, input string tag);
      rst       = r;
      sample_en = en;
      level     = v[N-1:0];
      if (r) begin
         exp_bit = 1'b0;
         k_model = 0;
      end else if (en) begin
         exp_bit = ((v + rev_of(k_model % SPAN)) >= SPAN);
         k_model++;
      end
      @(posedge clk);
      @(negedge clk);
      check(tag, out_rip, exp_bit);
      check("R8", out_cmp, out_rip);
   endtask

   task automatic do_reset();
      step(1'b1, 1'b0, 0, "R1");
      step(1'b1, 1'b1, SPAN - 1, "R1");
   endtask

   task automatic window(input int v);
      int ones = 0;
      for (int s = 0; s < SPAN; s++) begin
         step(1'b0, 1'b1, v, "R2");
         if (out_rip) ones++;
      end
      n_checks++;
      if (ones != v) begin
         n_fail++;
         $display("FAIL R6: actual %0d ones expected %0d", ones, v);
      end
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      end
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();

      // R4: zero level stays silent
      for (int s = 0; s < 24; s++) step(1'b0, 1'b1, 0, "R4");

      // R7: mid-scale alternates from 0 after reset
      do_reset();
      for (int s = 0; s < 16; s++) begin
         step(1'b0, 1'b1, SPAN / 2, "R7");
         check("R7", out_rip, (s % 2) == 1);
      end

      // R5: full scale with one gap per window
      do_reset();
      for (int s = 0; s < SPAN + 8; s++) begin
         step(1'b0, 1'b1, SPAN - 1, "R5");
         check("R5", out_rip, (s % SPAN) != 0);
      end

      // R6: density over full windows at several levels, started at varied counts
      window(1);
      window(100);
      step(1'b0, 1'b1, 7, "R2");
      window(300);
      window(SPAN - 2);

      // R3: enable gaps with a level changing while idle
      for (int s = 0; s < 400; s++) begin
         if ($urandom_range(0, 2) == 0) step(1'b0, 1'b1, $urandom_range(0, SPAN - 1), "R2");
         else step(1'b0, 1'b0, $urandom_range(0, SPAN - 1), "R3");
      end

      // R1: reset mid-stream, then first sample uses dither 0
      do_reset();
      step(1'b0, 1'b1, SPAN - 1, "R1");

      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      end
      $finish;
   end

endmodule